// File: doc/BRIEF.md
# Serial Configuration Loader with Chain Forwarding

This block takes in a configuration image one bit at a time on `din`. Each bit is taken on a rising edge of a configuration clock. It packs the bits into 32-bit words and exposes them on `cfg_words` for the logic it configures. When the fixed-length image has been taken in, it raises `done` and stops storing. From then on, every bit it receives is passed out on `dout` so that the next device in a daisy chain can be loaded from the same source.

There are two clock modes. In slave mode the configuration clock arrives on `cclk_in`, and both it and `din` are resynchronised into the system clock domain. In master mode the block makes the configuration clock itself by dividing the system clock, and drives it on `cclk_out`. That generated clock always starts at a slow default rate. Once the first stored word is complete, a two-bit speed field in that word selects a faster rate. The active-low `rst_n` input restarts the loader from scratch.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rst_n` is low and right after it is released, `done`, `dout` and `cclk_out` are 0 and `cfg_words` is all zeros.
- R2: With any `mode` other than 3'b000 (3'b111 is the normal slave code), one bit of `din` is captured per rising edge of `cclk_in`. Bit number n (counting from 0) of the image lands in word n/32, at bit position 31-(n mod 32). Word k occupies `cfg_words[32k+31:32k]`.
- R3: `done` stays 0 until the IMG_BITS-th bit has been captured. It is 1 from that capture onward until restart.
- R4: After `done`, `cfg_words` no longer changes. At each further rising configuration-clock edge, `dout` takes the bit captured at that edge.
- R5: `dout` is 0 while `done` is 0.
- R6: With `mode` = 3'b000, `cclk_out` toggles with a half period of SLOW_HALF system clocks (default 8) from restart onward.
- R7: In master mode, after the capture that completes word 0, the half period becomes max(1, SLOW_HALF >> s). Here s is word 0 bits [31:30], which are the first two image bits. Before that capture the slow rate holds.
- R8: In master mode, `din` is captured on the system clock edge at which `cclk_out` goes from 0 to 1.
- R9: A restart clears the bit count, `done`, `dout`, the stored words and the speed selection, and the generated clock resumes at the slow rate.
- R10: In slave mode `cclk_out` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous restart |
| mode | input | 3 | 3'b000 selects master mode; any other code selects slave mode |
| cclk_in | input | 1 | External configuration clock (slave mode) |
| din | input | 1 | Serial configuration data |
| cclk_out | output | 1 | Generated configuration clock (master mode) |
| dout | output | 1 | Forwarded serial data for the next device in the chain |
| done | output | 1 | Own image fully loaded |
| cfg_words | output | IMG_BITS rounded up to whole words × 32 | Stored configuration words, word 0 in the low bits |

## Verification
The assertions assume that `mode` is steady whenever `rst_n` is high. They also assume that in slave mode each phase of `cclk_in` lasts at least two system clocks, with `din` held steady across the whole high phase. The stimulus changes `mode` only while restart is held. It holds every `cclk_in` phase for eight system clocks and changes `din` only during the low phase. In master mode, the stimulus changes `din` only while `cclk_out` is observed low, so every capture sees a settled bit.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam logic [2:0] MODE_MASTER = 3'b000;
  localparam logic [2:0] MODE_SLAVE  = 3'b111;

  // Half period of the generated clock for a speed code: slow rate shifted down, floor 1.
  function automatic int unsigned half_for_sel(int unsigned slow_half, logic [1:0] sel);
    int unsigned h;
    h = slow_half >> sel;
    return (h == 0) ? 1 : h;
  endfunction

  // Number of whole words needed to hold an image.
  function automatic int unsigned words_for(int unsigned bits, int unsigned ww);
    return (bits + ww - 1) / ww;
  endfunction
endpackage

// File: rtl/cfgld_edge_sync.sv
module cfgld_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cclk_in,
  input  logic din,
  output logic rise,
  output logic din_s
);
  logic [2:0] c_q;
  logic [1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= '0;
      d_q <= '0;
    end else begin
      c_q <= {c_q[1:0], cclk_in};
      d_q <= {d_q[0], din};
    end
  end

  // Data path has the same two-stage depth as the clock path, so they stay aligned.
  assign rise  = c_q[1] & ~c_q[2];
  assign din_s = d_q[1];

  AST_SLAVE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R2
endmodule

// File: rtl/cfgld_clkgen.sv
module cfgld_clkgen
  import cfgld_pkg::*;
#(
  parameter int SLOW_HALF = 8,
  localparam int CNT_W = $clog2(SLOW_HALF + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] rate_sel,
  input  logic       rate_valid,
  output logic       cclk,
  output logic       rise
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_c;
  logic             q;
  logic             tick;

  always_comb begin
    if (rate_valid) half_c = CNT_W'(half_for_sel(SLOW_HALF, rate_sel));
    else            half_c = CNT_W'(SLOW_HALF);
  end

  // ">=" lets a rate change mid-phase finish the phase at once.
  assign tick = en && (cnt >= half_c - 1'b1);
  assign rise = tick & ~q;
  assign cclk = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      q   <= ~q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(SLOW_HALF)); // R6
  AST_GEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8
endmodule

// File: rtl/cfgld_store.sv
module cfgld_store #(
  parameter int IMG_BITS = 64,
  parameter int WORD_W   = 32,
  parameter int NWORDS   = 2,
  localparam int CNT_W   = $clog2(IMG_BITS + 1),
  localparam int WB      = $clog2(WORD_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rise,
  input  logic                     bit_in,
  output logic                     done,
  output logic [NWORDS*WORD_W-1:0] words,
  output logic [1:0]               rate_sel,
  output logic                     rate_valid,
  output logic                     pass_evt
);
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_word;
  logic              absorb;
  logic              word_end;
  logic              last_bit;

  assign next_word = {shreg[WORD_W-2:0], bit_in};
  assign absorb    = rise & ~done;
  assign last_bit  = (bit_cnt == CNT_W'(IMG_BITS - 1));
  assign word_end  = absorb && ((bit_cnt[WB-1:0] == {WB{1'b1}}) || last_bit);
  assign pass_evt  = rise & done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      done       <= 1'b0;
      rate_sel   <= '0;
      rate_valid <= 1'b0;
    end else if (absorb) begin
      bit_cnt <= bit_cnt + 1'b1;
      shreg   <= next_word;
      if (last_bit) done <= 1'b1;
      if (word_end && ((bit_cnt >> WB) == '0)) begin
        rate_sel   <= next_word[WORD_W-1 -: 2];
        rate_valid <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        w_q <= '0;
      else if (word_end && ((bit_cnt >> WB) == CNT_W'(g)))
        w_q <= next_word;
    end
    assign words[g*WORD_W +: WORD_W] = w_q;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(IMG_BITS)); // R3
  AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> bit_cnt == CNT_W'(IMG_BITS)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R3
  AST_WORDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(words)); // R4
  AST_RATE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rate_valid |=> $stable(rate_sel) && rate_valid); // R7
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int IMG_BITS  = 64,
  parameter int WORD_W    = 32,
  parameter int SLOW_HALF = 8,
  localparam int NWORDS   = words_for(IMG_BITS, WORD_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               mode,
  input  logic                     cclk_in,
  input  logic                     din,
  output logic                     cclk_out,
  output logic                     dout,
  output logic                     done,
  output logic [NWORDS*WORD_W-1:0] cfg_words
);
  logic       is_master;
  logic       sl_rise, sl_din;
  logic       gen_rise;
  logic       cap_rise, cap_bit;
  logic [1:0] rate_sel;
  logic       rate_valid;
  logic       pass_evt;

  assign is_master = (mode == MODE_MASTER);

  cfgld_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cclk_in(cclk_in), .din(din),
    .rise(sl_rise), .din_s(sl_din)
  );

  cfgld_clkgen #(.SLOW_HALF(SLOW_HALF)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(is_master),
    .rate_sel(rate_sel), .rate_valid(rate_valid),
    .cclk(cclk_out), .rise(gen_rise)
  );

  assign cap_rise = is_master ? gen_rise : sl_rise;
  assign cap_bit  = is_master ? din : sl_din;

  cfgld_store #(.IMG_BITS(IMG_BITS), .WORD_W(WORD_W), .NWORDS(NWORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .rise(cap_rise), .bit_in(cap_bit),
    .done(done), .words(cfg_words), .rate_sel(rate_sel),
    .rate_valid(rate_valid), .pass_evt(pass_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout <= 1'b0;
    else if (pass_evt) dout <= cap_bit;
  end

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !dout); // R5
  AST_SLAVE_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |=> !cclk_out); // R10
endmodule

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
  import cfgld_pkg::*;

  localparam int IMG = 64;
  localparam int SLOW = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  mode = MODE_SLAVE;
  logic        cclk_in = 0;
  logic        din = 0;
  logic        cclk_out, dout, done;
  logic [63:0] cfg_words;

  int nchk = 0;
  int nfail = 0;
  bit fin = 0;

  logic [1:0] exp_q[$];   // {is_forward, expected dout}
  event bit_evt;

  serial_cfg_loader #(.IMG_BITS(IMG), .WORD_W(32), .SLOW_HALF(SLOW)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cclk_in(cclk_in), .din(din),
    .cclk_out(cclk_out), .dout(dout), .done(done), .cfg_words(cfg_words)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_half(input logic [1:0] s);
    int h;
    h = SLOW / (1 << s);
    return (h < 1) ? 1 : h;
  endfunction

  // Monitor: pops the expectation for each captured bit and compares dout.
  initial begin
    forever begin
      @(bit_evt);
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        e = exp_q.pop_front();
        if (e[1]) chk(dout === e[0], "R4 forward", {63'b0, dout}, {63'b0, e[0]});
        else      chk(dout === 1'b0, "R5 quiet",   {63'b0, dout}, 64'b0);
      end
    end
  end

  // Slave driver: one bit per cclk_in period; index tells the expected dout role.
  task automatic s_bit(input logic b, input int idx);
    din = b;
    cclk_in = 0;
    repeat (8) @(negedge clk);
    cclk_in = 1;
    repeat (8) @(negedge clk);
    exp_q.push_back({idx >= IMG, (idx >= IMG) ? b : 1'b0});
    -> bit_evt;
  endtask

  // Master driver: returns the high-phase length that follows the capture.
  task automatic m_bit(input logic b, input int idx, output int hi);
    while (cclk_out) @(negedge clk);
    din = b;
    while (!cclk_out) @(negedge clk);
    exp_q.push_back({idx >= IMG, (idx >= IMG) ? b : 1'b0});
    -> bit_evt;
    hi = 0;
    while (cclk_out) begin
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic [2:0] m);
    rst_n = 0;
    mode = m;
    din = 0;
    cclk_in = 0;
    repeat (4) @(negedge clk);
    chk(done === 0 && dout === 0 && cclk_out === 0 && cfg_words === 64'b0,
        "R1 R9 restart", {done, dout, cclk_out, cfg_words[60:0]}, 64'b0);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, w1;
    logic [63:0] img;
    logic [7:0]  fwd;
    int hi;

    // ---------- slave mode ----------
    @(negedge clk);
    do_reset(MODE_SLAVE);
    chk(done === 0 && cfg_words === 64'b0, "R1 after release", {63'b0, done}, 64'b0);
    w0 = 32'hA5C3_0F96; w1 = 32'h3C5A_E719;
    img = {w0, w1};
    for (int i = 0; i < IMG; i++) begin
      s_bit(img[63 - i], i);
      if (i == IMG - 2) chk(done === 0, "R3 not early", {63'b0, done}, 64'b0);
      if (i == 10) chk(cclk_out === 0, "R10 slave clk low", {63'b0, cclk_out}, 64'b0);
    end
    chk(done === 1, "R3 done at full", {63'b0, done}, 64'b1);
    chk(cfg_words === {w1, w0}, "R2 packing", cfg_words, {w1, w0});
    fwd = 8'b1011_0010;
    for (int i = 0; i < 8; i++) s_bit(fwd[7 - i], IMG + i);
    chk(cfg_words === {w1, w0}, "R4 words frozen", cfg_words, {w1, w0});
    chk(cclk_out === 0, "R10 slave clk low end", {63'b0, cclk_out}, 64'b0);

    // ---------- master mode, speed code 2 ----------
    do_reset(MODE_MASTER);
    w0 = 32'h9E37_79B9; w1 = 32'h7F4A_7C15;
    img = {w0, w1};
    for (int i = 0; i < IMG; i++) begin
      m_bit(img[63 - i], i, hi);
      if (i == 0)  chk(hi == SLOW, "R6 slow start", 64'(hi), 64'(SLOW));
      if (i == 30) chk(hi == SLOW, "R7 slow until word0", 64'(hi), 64'(SLOW));
      if (i == 31) chk(hi == exp_half(w0[31:30]), "R7 fast after word0", 64'(hi), 64'(exp_half(w0[31:30])));
      if (i == 45) chk(hi == exp_half(w0[31:30]), "R7 fast holds", 64'(hi), 64'(exp_half(w0[31:30])));
    end
    chk(done === 1, "R3 master done", {63'b0, done}, 64'b1);
    chk(cfg_words === {w1, w0}, "R8 master capture", cfg_words, {w1, w0});
    fwd = 8'b0110_1101;
    for (int i = 0; i < 8; i++) m_bit(fwd[7 - i], IMG + i, hi);
    chk(cfg_words === {w1, w0}, "R4 master frozen", cfg_words, {w1, w0});

    // ---------- restart, master mode, speed code 3 ----------
    do_reset(MODE_MASTER);
    w0 = 32'hC000_0001;
    for (int i = 0; i < 34; i++) begin
      m_bit(w0[31 - (i % 32)], i, hi);
      if (i == 0)  chk(hi == SLOW, "R9 slow again", 64'(hi), 64'(SLOW));
      if (i == 31) chk(hi == exp_half(2'b11), "R7 fastest", 64'(hi), 64'(exp_half(2'b11)));
    end
    chk(done === 0, "R3 partial image", {63'b0, done}, 64'b0);
    chk(cfg_words[31:0] === w0, "R8 word0 master", {32'b0, cfg_words[31:0]}, {32'b0, w0});

    repeat (4) @(negedge clk);
    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule